// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell

This block is a programmable logic cell of the kind found in a field-programmable array. It holds two independent 4-input truth tables, called F and G here, and a small 3-input second-level table, H. H looks at the outputs of F and G plus one extra input `sel_e`. Wiring the same four variables to both F and G and programming H as a 2:1 selector on `sel_e` turns the cell into a general 5-input function by Shannon expansion. H can also form any other 3-input combination of F, G and `sel_e`.

All table bits come from a serial configuration chain that takes one bit per clock while `cfg_shift` is high. The cell drives the combinational F, G and H results. It also keeps a clocked copy of H that has its own clock enable and synchronous clear, and a select input chooses which copy of H appears on `h_out`. A power-on reset clears the configuration, so every table returns 0 until it is loaded.

Top module: `clb_cascade`

## Requirements
- R1: While and after `por_n` is low, every configuration bit and the held H value are 0, so `f_out`, `g_out`, `h_comb` and `h_out` are 0 for any input values.
- R2: Every rising edge with `cfg_shift` high moves one bit from `cfg_din` into the chain. After 40 such edges, the bit shifted k-th (k = 0 first) is F entry k for k < 16, G entry k-16 for 16 ≤ k < 32, and H entry k-32 for k ≥ 32. While `cfg_shift` is low the configuration does not change.
- R3: `f_out` equals F entry n, where n is the unsigned value of `f_in` (bit 3 is the most significant).
- R4: `g_out` equals G entry n, where n is the unsigned value of `g_in`. It does not depend on `f_in`.
- R5: `h_comb` equals H entry {`sel_e`, `g_out`, `f_out`}, with `sel_e` as bit 2 and `f_out` as bit 0.
- R6: With H loaded as 0xAC (bit i = entry i), `f_in` = `g_in` = {d,c,b,a}, G holding a 5-input function at e=0 and F holding it at e=1, `h_comb` equals that function of {e,d,c,b,a} for all 32 input combinations.
- R7: On a rising edge with `reg_clr` low and `hold_en` high, the held H takes the value of `h_comb`. With `hold_en` low it keeps its value.
- R8: On a rising edge with `reg_clr` high, the held H becomes 0 whatever `hold_en` is, and the configuration is unchanged.
- R9: `h_out` shows the held H when `use_reg` is 1 and `h_comb` when `use_reg` is 0.
- R10: `cfg_dout` shows the chain's oldest bit, which is F entry 0 once all 40 bits are loaded. It can feed the `cfg_din` of the next cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; clears the configuration and the held H |
| cfg_shift | input | 1 | Shift one configuration bit this cycle |
| cfg_din | input | 1 | Serial configuration data |
| cfg_dout | output | 1 | Serial configuration output (oldest chain bit) |
| f_in | input | 4 | Address inputs of table F |
| g_in | input | 4 | Address inputs of table G |
| sel_e | input | 1 | Extra variable into H (most significant H address bit) |
| hold_en | input | 1 | Clock enable of the held H |
| reg_clr | input | 1 | Synchronous clear of the held H |
| use_reg | input | 1 | 1: `h_out` shows the held H; 0: `h_out` shows `h_comb` |
| f_out | output | 1 | Combinational F result |
| g_out | output | 1 | Combinational G result |
| h_comb | output | 1 | Combinational H result |
| h_out | output | 1 | Selected H result |

## Verification
On every cycle the assertions check the chain's behaviour: it shifts or holds according to `cfg_shift`. They also check the held H: it loads when enabled, keeps its value when not enabled, and the clear takes priority over the load. Only the bench's scenarios can show the rest. That covers where each shifted bit ends up in F, G and H, that the table lookups are correct across all addresses, and that a 0xAC H table reproduces a full 5-input function. It also covers that the clear leaves the configuration unchanged and that `cfg_dout` matches F entry 0.

// File: rtl/clb_pkg.sv
package clb_pkg;
   localparam int unsigned H_INPUTS = 3;

   function automatic int unsigned table_depth(input int unsigned n_in);
      return 32'd1 << n_in;
   endfunction

   function automatic int unsigned chain_length(input int unsigned n_in);
      return 2 * table_depth(n_in) + table_depth(H_INPUTS);
   endfunction
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
   parameter int unsigned LEN = 40
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic           shift,
   input  logic           din,
   output logic [LEN-1:0] bits,
   output logic           dout
);
   generate
      if (LEN < 2) begin : g_bad_len
         $error("clb_cfg_chain: LEN must be at least 2");
      end
   endgenerate

   logic [LEN-1:0] chain_q;

   // New bits enter at the top; the oldest bit settles at index 0.
   always_ff @(posedge clk) begin
      if (!por_n)
         chain_q <= '0;
      else if (shift)
         chain_q <= {din, chain_q[LEN-1:1]};
   end

   assign bits = chain_q;
   assign dout = chain_q[0];

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      !shift |=> $stable(chain_q)); // R2
   AST_CFG_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      shift |=> chain_q[LEN-1] == $past(din)); // R2
   AST_CFG_ADVANCE: assert property (@(posedge clk) disable iff (!por_n)
      shift |=> chain_q[LEN-2:0] == $past(chain_q[LEN-1:1])); // R2
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
   parameter int unsigned N_IN = 4,
   localparam int unsigned DEPTH = 1 << N_IN
) (
   input  logic [DEPTH-1:0] truth,
   input  logic [N_IN-1:0]  addr,
   output logic             y
);
   generate
      if (N_IN < 1 || N_IN > 6) begin : g_bad_width
         $error("clb_lut: N_IN must be 1..6");
      end
   endgenerate

   assign y = truth[addr];
endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage #(
   parameter bit HAS_REG = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic h_d,
   input  logic hold_en,
   input  logic reg_clr,
   input  logic use_reg,
   output logic h_out
);
   generate
      if (HAS_REG) begin : g_reg
         logic h_q;

         always_ff @(posedge clk) begin
            if (!por_n || reg_clr)
               h_q <= 1'b0;
            else if (hold_en)
               h_q <= h_d;
         end

         assign h_out = use_reg ? h_q : h_d;

         AST_REG_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
            reg_clr |=> !h_q); // R8
         AST_REG_LOAD: assert property (@(posedge clk) disable iff (!por_n)
            (!reg_clr && hold_en) |=> h_q == $past(h_d)); // R7
         AST_REG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
            (!reg_clr && !hold_en) |=> $stable(h_q)); // R7
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, por_n, hold_en, reg_clr, use_reg};
         assign h_out = h_d;
      end
   endgenerate
endmodule

// File: rtl/clb_cascade.sv
module clb_cascade #(
   parameter int unsigned LUT_IN  = 4,
   parameter bit          HAS_REG = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              cfg_shift,
   input  logic              cfg_din,
   output logic              cfg_dout,
   input  logic [LUT_IN-1:0] f_in,
   input  logic [LUT_IN-1:0] g_in,
   input  logic              sel_e,
   input  logic              hold_en,
   input  logic              reg_clr,
   input  logic              use_reg,
   output logic              f_out,
   output logic              g_out,
   output logic              h_comb,
   output logic              h_out
);
   import clb_pkg::*;

   localparam int unsigned LDEPTH  = table_depth(LUT_IN);
   localparam int unsigned HDEPTH  = table_depth(H_INPUTS);
   localparam int unsigned CFG_LEN = chain_length(LUT_IN);

   generate
      if (LUT_IN < 2 || LUT_IN > 6) begin : g_bad_lut
         $error("clb_cascade: LUT_IN must be 2..6");
      end
   endgenerate

   logic [CFG_LEN-1:0] cfg;
   logic [1:0]         first_level;
   logic [LUT_IN-1:0]  first_addr [2];

   clb_cfg_chain #(.LEN(CFG_LEN)) u_chain (
      .clk   (clk),
      .por_n (por_n),
      .shift (cfg_shift),
      .din   (cfg_din),
      .bits  (cfg),
      .dout  (cfg_dout)
   );

   assign first_addr[0] = f_in;
   assign first_addr[1] = g_in;

   // Slot 0 = F (first in the chain), slot 1 = G.
   generate
      for (genvar i = 0; i < 2; i++) begin : g_first
         clb_lut #(.N_IN(LUT_IN)) u_lut (
            .truth (cfg[i*LDEPTH +: LDEPTH]),
            .addr  (first_addr[i]),
            .y     (first_level[i])
         );
      end
   endgenerate

   clb_lut #(.N_IN(H_INPUTS)) u_hlut (
      .truth (cfg[2*LDEPTH +: HDEPTH]),
      .addr  ({sel_e, first_level[1], first_level[0]}),
      .y     (h_comb)
   );

   assign f_out = first_level[0];
   assign g_out = first_level[1];

   clb_out_stage #(.HAS_REG(HAS_REG)) u_out (
      .clk     (clk),
      .por_n   (por_n),
      .h_d     (h_comb),
      .hold_en (hold_en),
      .reg_clr (reg_clr),
      .use_reg (use_reg),
      .h_out   (h_out)
   );

   AST_CLR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!por_n)
      (reg_clr && !cfg_shift) |=> $stable(cfg)); // R8
endmodule

// File: tb/sim_clb_cascade.sv
module sim_clb_cascade;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       por_n, cfg_shift, cfg_din, sel_e, hold_en, reg_clr, use_reg;
   logic [3:0] f_in, g_in;
   logic       cfg_dout, f_out, g_out, h_comb, h_out;

   int checks = 0;
   int errors = 0;

   logic [15:0] ft, gt;
   logic [7:0]  ht;

   always #(CLK_PERIOD/2) clk = ~clk;

   clb_cascade u0 (
      .clk(clk), .por_n(por_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
      .cfg_dout(cfg_dout), .f_in(f_in), .g_in(g_in), .sel_e(sel_e),
      .hold_en(hold_en), .reg_clr(reg_clr), .use_reg(use_reg),
      .f_out(f_out), .g_out(g_out), .h_comb(h_comb), .h_out(h_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic to_neg();
      @(negedge clk);
   endtask

   // Shifts F then G then H, each from entry 0.
   task automatic load_cfg(input logic [15:0] f, input logic [15:0] g, input logic [7:0] h);
      logic [39:0] stream;
      stream = {h, g, f};
      ft = f; gt = g; ht = h;
      for (int k = 0; k < 40; k++) begin
         to_neg();
         cfg_shift = 1'b1;
         cfg_din = stream[k];
      end
      to_neg();
      cfg_shift = 1'b0;
      cfg_din = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      por_n = 1'b0;
      repeat (3) to_neg();
      for (int n = 0; n < 16; n += 5) begin
         f_in = 4'(n); g_in = 4'(15 - n); sel_e = n[0]; use_reg = n[1];
         #1;
         chk("R1 f_out", f_out, 1'b0);
         chk("R1 g_out", g_out, 1'b0);
         chk("R1 h_comb", h_comb, 1'b0);
         chk("R1 h_out", h_out, 1'b0);
      end
      por_n = 1'b1;
      to_neg();
      #1;
      chk("R1 f_out after release", f_out, 1'b0);
   endtask

   task automatic t_tables(input logic [15:0] f, input logic [15:0] g, input logic [7:0] h);
      load_cfg(f, g, h);
      use_reg = 1'b0;
      for (int n = 0; n < 16; n++) begin
         f_in = 4'(n); g_in = 4'((n * 7 + 3) & 15);
         for (int e = 0; e < 2; e++) begin
            sel_e = e[0];
            #1;
            chk("R2/R3 f_out", f_out, ft[f_in]);
            chk("R2/R4 g_out", g_out, gt[g_in]);
            chk("R5 h_comb", h_comb, ht[{sel_e, gt[g_in], ft[f_in]}]);
            chk("R9 bypass h_out", h_out, ht[{sel_e, gt[g_in], ft[f_in]}]);
         end
      end
      chk("R10 cfg_dout", cfg_dout, ft[0]);
   endtask

   function automatic logic fn5(input logic [4:0] x);
      return ($countones(x) >= 3) ^ (x[4] & x[0]);
   endfunction

   task automatic t_shannon();
      logic [15:0] f, g;
      for (int n = 0; n < 16; n++) begin
         g[n] = fn5({1'b0, 4'(n)});
         f[n] = fn5({1'b1, 4'(n)});
      end
      load_cfg(f, g, 8'hAC);
      for (int x = 0; x < 32; x++) begin
         f_in = 4'(x); g_in = 4'(x); sel_e = x[4];
         #1;
         chk("R6 five-input", h_comb, fn5(5'(x)));
      end
   endtask

   task automatic t_cfg_hold();
      to_neg();
      cfg_shift = 1'b0;
      for (int k = 0; k < 6; k++) begin
         cfg_din = k[0];
         to_neg();
      end
      for (int n = 0; n < 16; n += 3) begin
         f_in = 4'(n); g_in = 4'(n); sel_e = 1'b1;
         #1;
         chk("R2 hold f_out", f_out, ft[f_in]);
         chk("R2 hold g_out", g_out, gt[g_in]);
      end
   endtask

   task automatic t_register();
      logic want;
      use_reg = 1'b1;
      reg_clr = 1'b0;
      for (int n = 0; n < 8; n++) begin
         to_neg();
         f_in = 4'(n * 3); g_in = 4'(n * 5); sel_e = n[1];
         hold_en = 1'b1;
         #1;
         want = h_comb;
         to_neg();
         hold_en = 1'b0;
         f_in = ~f_in; sel_e = ~sel_e;
         #1;
         chk("R7/R9 load", h_out, want);
         to_neg();
         to_neg();
         #1;
         chk("R7 hold", h_out, want);
      end
   endtask

   task automatic t_clear();
      logic [15:0] f, g;
      f = 16'hFFFF; g = 16'h0F0F;
      load_cfg(f, g, 8'hFF);
      use_reg = 1'b1;
      to_neg();
      hold_en = 1'b1;
      to_neg();
      #1;
      chk("R7 load one", h_out, 1'b1);
      reg_clr = 1'b1;
      to_neg();
      reg_clr = 1'b0;
      hold_en = 1'b0;
      #1;
      chk("R8 clear", h_out, 1'b0);
      use_reg = 1'b0;
      #1;
      chk("R9 comb path", h_out, 1'b1);
      for (int n = 0; n < 16; n += 5) begin
         g_in = 4'(n); #1;
         chk("R8 cfg kept g", g_out, gt[g_in]);
      end
      chk("R8 cfg kept dout", cfg_dout, 1'b1);
      chk("R10 cfg_dout", cfg_dout, ft[0]);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cfg_shift = 1'b0; cfg_din = 1'b0; sel_e = 1'b0; hold_en = 1'b0;
      reg_clr = 1'b0; use_reg = 1'b0; f_in = '0; g_in = '0; por_n = 1'b0;
      t_reset();
      t_tables(16'h6996, 16'h8000, 8'hE8);
      t_tables(16'h1235, 16'hBEEF, 8'h5A);
      t_shannon();
      t_cfg_hold();
      t_register();
      t_clear();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule